// File: doc/BRIEF.md
# Comparator Control Register Bank

This block keeps the control state for a pair of voltage comparators and turns each comparator's raw decision into the value presented at its output pin. Every comparator owns one control word and four spare data words. A host reaches all of them through a one-cycle parallel command port. It can write or read the control word, write or read any data word, or copy a chosen data word into the control word in one command.

Three bits of each control word shape the output path. The enable bit lets the comparator decision reach the pin. The latch bit freezes the pin at the decision seen when the latch took effect. The shutdown bit powers the analog section down, and while it is set the pin is forced low and left undriven. The comparator itself and the serial front end that would normally issue the commands sit outside the block.

Top module: `ccrb_top`

## Requirements
- R1: After reset every control word and every data word reads zero, `rd_valid` is low, and `cmp_out`, `cmp_oe` and `pwr_down` are all low.
- R2: Command code 0 writes `cmd_wdata` into the control word of the comparator chosen by `cmd_cmp_sel`, and the new value is in effect from the next cycle.
- R3: Command code 2 writes `cmd_wdata` into data word `cmd_reg_sel` of the chosen comparator, and command code 3 reads it back; the other data words are unchanged.
- R4: Command code 4 copies data word `cmd_reg_sel` of the chosen comparator into that comparator's control word in one cycle and leaves the data word unchanged.
- R5: Control bit 2 is the enable. With enable set and shutdown clear, `cmp_oe` is high and `cmp_out` carries the comparator value; with enable clear, `cmp_oe` and `cmp_out` are low.
- R6: Control bit 1 is the latch. While it is set, `cmp_out` holds the `cmp_raw` value sampled at the clock edge that set the latch and ignores later changes on `cmp_raw`; with latch clear, `cmp_out` follows `cmp_raw` in the same cycle.
- R7: Control bit 0 is the shutdown. While it is set, `pwr_down` is high and both `cmp_out` and `cmp_oe` are low, whatever the enable and latch bits hold.
- R8: A command changes only the comparator selected by `cmd_cmp_sel`; the other comparator's words and outputs are untouched.
- R9: Command codes 1 (read control word) and 3 (read data word) return the addressed word on `rd_data` with `rd_valid` high in the cycle after the command, and `rd_valid` is low in every other cycle.
- R10: Command codes 5, 6 and 7 change no register and raise no read response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code: 0 write control, 1 read control, 2 write data, 3 read data, 4 copy data to control |
| cmd_cmp_sel | input | 1 | Comparator addressed by the command |
| cmd_reg_sel | input | 2 | Data word addressed by write, read or copy |
| cmd_wdata | input | 8 | Write value |
| cmp_raw | input | 2 | Raw comparator decisions, one bit per comparator |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Read response value |
| cmp_out | output | 2 | Output pin values, one bit per comparator |
| cmp_oe | output | 2 | High when the pin is driven by its comparator |
| pwr_down | output | 2 | Analog power-down request per comparator |

## Verification
The hardest case to reach is a latch that takes effect through a copy from a data word, on a cycle when the raw decision is also changing, because the held value then depends on which edge sampled the input. The stimulus preloads data words with latch and enable patterns, toggles `cmp_raw` on the same cycle as the copy command and on the cycles that follow, and then releases the latch with a direct write. Shutdown is applied on top of enabled and latched states so that the forced-low output is seen over a frozen pin. Every cycle is compared with a behavioural model of both comparators.

// File: rtl/ccrb_pkg.sv
// Package: shared command codes and control-word bit positions for the
// comparator control register bank. Assumes a 3-bit command code.
package ccrb_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ACR_WR  = 3'd0,
        OP_ACR_RD  = 3'd1,
        OP_DAT_WR  = 3'd2,
        OP_DAT_RD  = 3'd3,
        OP_XFER    = 3'd4
    } ccrb_op_e;

    localparam int BIT_EN    = 2;
    localparam int BIT_LATCH = 1;
    localparam int BIT_SHDN  = 0;
endpackage

// File: rtl/ccrb_cmd_decode.sv
// Module: ccrb_cmd_decode
// Turns one parallel command into per-comparator write/copy strobes and a
// read request. Assumes at most one command per cycle; unknown codes are
// dropped without any strobe.
module ccrb_cmd_decode
    import ccrb_pkg::*;
#(
    parameter int NUM_CMP = 2,
    localparam int CSEL_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                 cmd_valid,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [CSEL_W-1:0]    cmd_cmp_sel,
    output logic [NUM_CMP-1:0]   acr_wr,
    output logic [NUM_CMP-1:0]   dat_wr,
    output logic [NUM_CMP-1:0]   xfer,
    output logic                 rd_req,
    output logic                 rd_is_acr
);
    logic op_acr_wr, op_dat_wr, op_xfer;

    // Classify the command code into the kinds of action it requests.
    always_comb begin
        op_acr_wr = 1'b0;
        op_dat_wr = 1'b0;
        op_xfer   = 1'b0;
        rd_req    = 1'b0;
        rd_is_acr = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ACR_WR: op_acr_wr = 1'b1;
                OP_ACR_RD: begin rd_req = 1'b1; rd_is_acr = 1'b1; end
                OP_DAT_WR: op_dat_wr = 1'b1;
                OP_DAT_RD: rd_req = 1'b1;
                OP_XFER:   op_xfer = 1'b1;
                default:   ;
            endcase
        end
    end

    // Route the action strobes to the selected comparator only.
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_sel
        logic hit;
        assign hit       = (cmd_cmp_sel == CSEL_W'(c));
        assign acr_wr[c] = op_acr_wr & hit;
        assign dat_wr[c] = op_dat_wr & hit;
        assign xfer[c]   = op_xfer & hit;
    end
endmodule

// File: rtl/ccrb_channel.sv
// Module: ccrb_channel
// One comparator's control word, its data words and its output shaping.
// Assumes write and copy strobes are never both high in one cycle.
// The held value tracks the raw input while latch is clear, so it captures
// the raw value at the edge that sets the latch.
module ccrb_channel
    import ccrb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_DREG = 4,
    localparam int RSEL_W  = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acr_wr,
    input  logic                              dat_wr,
    input  logic                              xfer,
    input  logic [RSEL_W-1:0]                 reg_sel,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              raw,
    output logic [DATA_W-1:0]                 acr_q,
    output logic [NUM_DREG-1:0][DATA_W-1:0]   dreg_q,
    output logic                              pin_out,
    output logic                              pin_oe,
    output logic                              pd
);
    logic hold_q;
    logic en, latched;

    // Control word: direct write or copy from a data word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acr_q <= '0;
        else if (acr_wr)
            acr_q <= wdata;
        else if (xfer)
            acr_q <= dreg_q[reg_sel];
    end

    // Data words, one register per slot.
    for (genvar r = 0; r < NUM_DREG; r++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (!rst_n)
                dreg_q[r] <= '0;
            else if (dat_wr && (reg_sel == RSEL_W'(r)))
                dreg_q[r] <= wdata;
        end
    end

    // Held comparator value: follows raw until the latch bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (!acr_q[BIT_LATCH])
            hold_q <= raw;
    end

    assign en      = acr_q[BIT_EN];
    assign latched = acr_q[BIT_LATCH];
    assign pd      = acr_q[BIT_SHDN];

    // Pin shaping: shutdown dominates, then enable, then latch selects source.
    always_comb begin
        pin_oe  = en & ~pd;
        pin_out = pin_oe & (latched ? hold_q : raw);
    end
endmodule

// File: rtl/ccrb_read_mux.sv
// Module: ccrb_read_mux
// Registered read port: selects a control or data word and presents it one
// cycle after the request. Assumes the word arrays are registered upstream.
module ccrb_read_mux #(
    parameter int NUM_CMP  = 2,
    parameter int NUM_DREG = 4,
    parameter int DATA_W   = 8,
    localparam int CSEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
    localparam int RSEL_W  = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           rd_req,
    input  logic                                           rd_is_acr,
    input  logic [CSEL_W-1:0]                              cmp_sel,
    input  logic [RSEL_W-1:0]                              reg_sel,
    input  logic [NUM_CMP-1:0][DATA_W-1:0]                 acr_all,
    input  logic [NUM_CMP-1:0][NUM_DREG-1:0][DATA_W-1:0]   dreg_all,
    output logic                                           rd_valid,
    output logic [DATA_W-1:0]                              rd_data
);
    logic [DATA_W-1:0] pick;

    // Choose the addressed word.
    always_comb begin
        if (rd_is_acr)
            pick = acr_all[cmp_sel];
        else
            pick = dreg_all[cmp_sel][reg_sel];
    end

    // Register the response; data holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= pick;
        end
    end
endmodule

// File: rtl/ccrb_top.sv
// Module: ccrb_top
// Comparator control register bank: command decode, one channel per
// comparator, and a registered read port. Assumes a synchronous active-low
// reset and a raw comparator input already in the clock domain.
module ccrb_top
    import ccrb_pkg::*;
#(
    parameter int NUM_CMP  = 2,
    parameter int NUM_DREG = 4,
    parameter int DATA_W   = 8,
    localparam int CSEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
    localparam int RSEL_W  = (NUM_DREG > 1) ? $clog2(NUM_DREG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [CSEL_W-1:0]    cmd_cmp_sel,
    input  logic [RSEL_W-1:0]    cmd_reg_sel,
    input  logic [DATA_W-1:0]    cmd_wdata,
    input  logic [NUM_CMP-1:0]   cmp_raw,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_CMP-1:0]   cmp_out,
    output logic [NUM_CMP-1:0]   cmp_oe,
    output logic [NUM_CMP-1:0]   pwr_down
);
    logic [NUM_CMP-1:0]                              acr_wr, dat_wr, xfer;
    logic                                            rd_req, rd_is_acr;
    logic [NUM_CMP-1:0][DATA_W-1:0]                  acr_bus;
    logic [NUM_CMP-1:0][NUM_DREG-1:0][DATA_W-1:0]    dreg_bus;

    ccrb_cmd_decode #(.NUM_CMP(NUM_CMP)) dec_i (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_cmp_sel (cmd_cmp_sel),
        .acr_wr      (acr_wr),
        .dat_wr      (dat_wr),
        .xfer        (xfer),
        .rd_req      (rd_req),
        .rd_is_acr   (rd_is_acr)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_ch
        ccrb_channel #(.DATA_W(DATA_W), .NUM_DREG(NUM_DREG)) ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .acr_wr  (acr_wr[c]),
            .dat_wr  (dat_wr[c]),
            .xfer    (xfer[c]),
            .reg_sel (cmd_reg_sel),
            .wdata   (cmd_wdata),
            .raw     (cmp_raw[c]),
            .acr_q   (acr_bus[c]),
            .dreg_q  (dreg_bus[c]),
            .pin_out (cmp_out[c]),
            .pin_oe  (cmp_oe[c]),
            .pd      (pwr_down[c])
        );
    end

    ccrb_read_mux #(.NUM_CMP(NUM_CMP), .NUM_DREG(NUM_DREG), .DATA_W(DATA_W)) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_is_acr (rd_is_acr),
        .cmp_sel   (cmd_cmp_sel),
        .reg_sel   (cmd_reg_sel),
        .acr_all   (acr_bus),
        .dreg_all  (dreg_bus),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/ccrb_checker.sv
// Module: ccrb_checker
// Temporal checks on the register bank, bound to ccrb_top. Assumes the
// control-word bus of the top is visible as acr_bus.
module ccrb_checker
    import ccrb_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int DATA_W  = 8,
    localparam int CSEL_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cmd_valid,
    input logic [OP_W-1:0]                   cmd_op,
    input logic [CSEL_W-1:0]                 cmd_cmp_sel,
    input logic [DATA_W-1:0]                 cmd_wdata,
    input logic [NUM_CMP-1:0]                cmp_raw,
    input logic [NUM_CMP-1:0]                cmp_out,
    input logic [NUM_CMP-1:0]                cmp_oe,
    input logic [NUM_CMP-1:0]                pwr_down,
    input logic                              rd_valid,
    input logic [NUM_CMP-1:0][DATA_W-1:0]    acr_bus
);
    logic rd_cmd;
    assign rd_cmd = cmd_valid && (cmd_op == OP_ACR_RD || cmd_op == OP_DAT_RD);

    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> rd_valid);
    p_no_stray_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cmd |=> !rd_valid);

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_chk
        p_shutdown_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_down[c] |-> (!cmp_oe[c] && !cmp_out[c]));
        p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !acr_bus[c][BIT_EN] |-> (!cmp_oe[c] && !cmp_out[c]));
        p_enabled_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (acr_bus[c][BIT_EN] && !pwr_down[c]) |-> cmp_oe[c]);
        p_follow_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_oe[c] && !acr_bus[c][BIT_LATCH]) |-> (cmp_out[c] == cmp_raw[c]));
        p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_oe[c] && $past(cmp_oe[c]) && acr_bus[c][BIT_LATCH]
             && $past(acr_bus[c][BIT_LATCH])) |-> $stable(cmp_out[c]));
        p_acr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ACR_WR && cmd_cmp_sel == CSEL_W'(c))
            |=> (acr_bus[c] == $past(cmd_wdata)));
    end
endmodule

bind ccrb_top ccrb_checker #(.NUM_CMP(NUM_CMP), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_cmp_sel (cmd_cmp_sel),
    .cmd_wdata   (cmd_wdata),
    .cmp_raw     (cmp_raw),
    .cmp_out     (cmp_out),
    .cmp_oe      (cmp_oe),
    .pwr_down    (pwr_down),
    .rd_valid    (rd_valid),
    .acr_bus     (acr_bus)
);

// File: tb/ccrb_top_tb_top.sv
// Bench for ccrb_top: directed command sequences plus a behavioural model
// of both comparators compared on every falling edge.
module ccrb_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       cmd_cmp_sel = 1'b0;
    logic [1:0] cmd_reg_sel = 2'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic [1:0] cmp_raw = 2'b00;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [1:0] cmp_out, cmp_oe, pwr_down;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    ccrb_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_cmp_sel(cmd_cmp_sel), .cmd_reg_sel(cmd_reg_sel),
        .cmd_wdata(cmd_wdata), .cmp_raw(cmp_raw), .rd_valid(rd_valid),
        .rd_data(rd_data), .cmp_out(cmp_out), .cmp_oe(cmp_oe),
        .pwr_down(pwr_down)
    );

    // Behavioural model state.
    int m_acr [2];
    int m_dat [2][4];
    int m_hold [2];
    int m_rdv;
    int m_rdd;

    task automatic chk(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge using the inputs driven earlier.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_acr[c] = 0; m_hold[c] = 0;
                for (int r = 0; r < 4; r++) m_dat[c][r] = 0;
            end
            m_rdv = 0; m_rdd = 0;
        end else begin
            for (int c = 0; c < 2; c++)
                if (((m_acr[c] >> 1) & 1) == 0) m_hold[c] = int'(cmp_raw[c]);
            m_rdv = 0;
            if (cmd_valid) begin
                case (cmd_op)
                    3'd0: m_acr[cmd_cmp_sel] = int'(cmd_wdata);
                    3'd1: begin m_rdv = 1; m_rdd = m_acr[cmd_cmp_sel]; end
                    3'd2: m_dat[cmd_cmp_sel][cmd_reg_sel] = int'(cmd_wdata);
                    3'd3: begin m_rdv = 1; m_rdd = m_dat[cmd_cmp_sel][cmd_reg_sel]; end
                    3'd4: m_acr[cmd_cmp_sel] = m_dat[cmd_cmp_sel][cmd_reg_sel];
                    default: ;
                endcase
            end
        end
    end

    // Compare every output with the model at each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(rd_valid), m_rdv, "R9 rd_valid");
            if (m_rdv == 1) chk(int'(rd_data), m_rdd, "R9 rd_data");
            for (int c = 0; c < 2; c++) begin
                int en, la, pd, oe, ov;
                en = (m_acr[c] >> 2) & 1;
                la = (m_acr[c] >> 1) & 1;
                pd = m_acr[c] & 1;
                oe = en & (1 - pd);
                ov = oe & (la ? m_hold[c] : int'(cmp_raw[c]));
                chk(int'(pwr_down[c]), pd, "R7 pwr_down");
                chk(int'(cmp_oe[c]), oe, "R5 cmp_oe");
                chk(int'(cmp_out[c]), ov, "R6 cmp_out");
            end
        end
    end

    task automatic cmd(input int op, input int sel, input int rs, input int wd);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_cmp_sel = 1'(sel);
        cmd_reg_sel = 2'(rs); cmd_wdata = 8'(wd);
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input int op, input int sel, input int rs, input int exp, input string tag);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_cmp_sel = 1'(sel);
        cmd_reg_sel = 2'(rs);
        @(posedge clk); #1;
        chk(int'(rd_valid), 1, tag);
        chk(int'(rd_data), exp, tag);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic raw_set(input int v);
        @(posedge clk); #2; cmp_raw = 2'(v);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(int'(rd_valid), 0, "R1 rd_valid");
        chk(int'({cmp_out, cmp_oe, pwr_down}), 0, "R1 outputs");
        rd(1, 0, 0, 0, "R1 acr0");
        rd(3, 1, 3, 0, "R1 dat1.3");

        // R2: direct control write, enable only
        cmd(0, 0, 0, 8'h04);
        rd(1, 0, 0, 8'h04, "R2 acr0");
        raw_set(2'b01); @(negedge clk);
        chk(int'(cmp_out[0]), 1, "R5 follow high");
        raw_set(2'b00); @(negedge clk);
        chk(int'(cmp_out[0]), 0, "R5 follow low");

        // R3: data words, each slot distinct
        for (int r = 0; r < 4; r++) cmd(2, 0, r, 8'h10 + r);
        cmd(2, 0, 2, 8'h06);
        for (int r = 0; r < 4; r++)
            rd(3, 0, r, (r == 2) ? 8'h06 : 8'h10 + r, "R3 dat0");

        // R8: other comparator untouched
        rd(3, 1, 2, 0, "R8 dat1 untouched");
        rd(1, 1, 0, 0, "R8 acr1 untouched");
        chk(int'(cmp_oe[1]), 0, "R8 oe1");

        // R4 + R6: copy latch+enable while raw is changing
        raw_set(2'b01);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_cmp_sel = 1'b0; cmd_reg_sel = 2'd2;
        @(posedge clk); #2;
        cmd_valid = 1'b0; cmp_raw = 2'b00;
        @(negedge clk);
        chk(int'(cmp_out[0]), 1, "R6 held after copy");
        raw_set(2'b01); raw_set(2'b00); @(negedge clk);
        chk(int'(cmp_out[0]), 1, "R6 still held");
        rd(1, 0, 0, 8'h06, "R4 acr0 copied");
        rd(3, 0, 2, 8'h06, "R4 source kept");

        // R7: shutdown on top of latch
        cmd(0, 0, 0, 8'h07); @(negedge clk);
        chk(int'(pwr_down[0]), 1, "R7 pd");
        chk(int'(cmp_out[0]), 0, "R7 forced low");
        // release latch, follow again
        cmd(0, 0, 0, 8'h04);
        raw_set(2'b11); @(negedge clk);
        chk(int'(cmp_out[0]), 1, "R6 release");

        // R10: undefined codes do nothing
        cmd(5, 0, 0, 8'hFF); cmd(6, 1, 1, 8'hFF); cmd(7, 0, 3, 8'hFF);
        @(negedge clk);
        chk(int'(rd_valid), 0, "R10 no response");
        rd(1, 0, 0, 8'h04, "R10 acr0 kept");
        rd(3, 1, 1, 0, "R10 dat1 kept");

        // Comparator 1: latch set directly while raw toggles
        raw_set(2'b10);
        cmd(0, 1, 0, 8'h06);
        raw_set(2'b00);
        for (int i = 0; i < 6; i++) raw_set(i % 2 ? 2'b10 : 2'b00);
        @(negedge clk);
        chk(int'(cmp_out[1]), 1, "R6 cmp1 held");
        cmd(0, 1, 0, 8'h01); @(negedge clk);
        chk(int'(pwr_down[1]), 1, "R7 pd1");

        repeat (4) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule